// File: doc/BRIEF.md
# Multi-Channel Servo Pulse Generator

This block drives a bank of hobby-servo control outputs. Every channel shares one frame counter that steps once per clock tick, which is 20 ns at 50 MHz. At the start of each frame every enabled channel goes high. Each channel then goes low once its own pulse-width count has elapsed. The frame length and all pulse widths are counted in clock ticks. A frame value of 1,000,000 ticks gives a 20 ms frame. A pulse of `t` microseconds needs `t * 1000 / 20` ticks.

The host reaches the block through a plain register port. It presents an address and a 32-bit word with a write strobe, and it reads through a combinational data output. Values written to the period, width and enable registers are held as pending copies. They reach the outputs together at the next frame boundary, so a pulse that is already running is never cut short or stretched. The enable register reads back, so the host can switch one channel with a read-modify-write.

Top module: `servo_pulse_gen`

## Requirements
- R1: After reset, all outputs are low. Address 0x00 reads the reset frame length (parameter `RST_PERIOD`). The enable register, every width register and the status register all read 0.
- R2: One shared counter defines the frame, and each frame lasts exactly the programmed period in ticks (address 0x00). All enabled channels with a nonzero width rise together on the first tick of a frame.
- R3: An enabled channel `n` stays high for exactly `W` ticks at the start of each frame, where `W` is the value at address 0x10+n.
- R4: A width of 0 keeps the channel low for the whole frame. A width equal to or above the period keeps it high for the whole frame, with no low tick at the boundary.
- R5: Bit `n` of the enable register (address 0x01) enables channel `n`. A disabled channel stays low.
- R6: Writes to the period, width and enable registers take effect only at the next frame boundary. The frame in progress completes with the old values.
- R7: `rdata_o` shows, in the same cycle, the last value written to the register at `addr_i`. A read-modify-write of the enable register changes only the intended bit.
- R8: A write to any address other than 0x00, 0x01, 0x02 or 0x10 to 0x10+NUM_CH-1 sets bit 0 of the status register (address 0x02) and changes no other register. Any write to address 0x02 clears that bit. A read of an unused address returns 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Timing clock; one tick per cycle |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Write strobe for the register port |
| addr_i | input | ADDR_W | Register address, used for both reads and writes |
| wdata_i | input | DATA_W | Write data |
| rdata_o | output | DATA_W | Read data for `addr_i`, combinational |
| servo_o | output | NUM_CH | Servo pulse outputs, bit n drives channel n |

## Verification
The hardest case to reach from the ports is a register write that lands inside a frame while pulses are already running. The old values must finish that frame, and the new ones must appear exactly one boundary later. To reach it, the stimulus waits for the rising edge of channel 0, which marks a frame start. Within the next few ticks it rewrites one channel's width and the frame period. The scoreboard is loaded beforehand with the old width and old frame length for the current frame and the new values for the two frames after it. It also checks one channel with a width of 1 and one with a width equal to the new period, to cover the edges of the comparison.

// File: rtl/servo_pkg.sv
package servo_pkg;
  // register map; widths occupy ADDR_WIDTH0 .. ADDR_WIDTH0+NUM_CH-1
  localparam int unsigned ADDR_PERIOD = 0;
  localparam int unsigned ADDR_ENABLE = 1;
  localparam int unsigned ADDR_STATUS = 2;
  localparam int unsigned ADDR_WIDTH0 = 16;
endpackage

// File: rtl/servo_regs.sv
module servo_regs import servo_pkg::*; #(
  parameter int unsigned NUM_CH     = 8,
  parameter int unsigned CNT_W      = 32,
  parameter int unsigned ADDR_W     = 8,
  parameter int unsigned DATA_W     = 32,
  parameter int unsigned RST_PERIOD = 1_000_000
) (
  input  logic                           clk_i,
  input  logic                           rst_ni,
  input  logic                           wr_en_i,
  input  logic [ADDR_W-1:0]              addr_i,
  input  logic [DATA_W-1:0]              wdata_i,
  output logic [DATA_W-1:0]              rdata_o,
  output logic [CNT_W-1:0]               period_o,
  output logic [NUM_CH-1:0][CNT_W-1:0]   width_o,
  output logic [NUM_CH-1:0]              enable_o
);
  logic              hit_period, hit_enable, hit_status, hit_any;
  logic [NUM_CH-1:0] hit_width;
  logic              err_q;

  assign hit_period = (addr_i == ADDR_W'(ADDR_PERIOD));
  assign hit_enable = (addr_i == ADDR_W'(ADDR_ENABLE));
  assign hit_status = (addr_i == ADDR_W'(ADDR_STATUS));

  for (genvar n = 0; n < NUM_CH; n++) begin : g_dec
    assign hit_width[n] = (addr_i == ADDR_W'(ADDR_WIDTH0 + n));
  end

  assign hit_any = hit_period | hit_enable | hit_status | (|hit_width);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      period_o <= CNT_W'(RST_PERIOD);
      width_o  <= '0;
      enable_o <= '0;
      err_q    <= 1'b0;
    end else if (wr_en_i) begin
      if (hit_period) period_o <= wdata_i[CNT_W-1:0];
      if (hit_enable) enable_o <= wdata_i[NUM_CH-1:0];
      for (int n = 0; n < NUM_CH; n++)
        if (hit_width[n]) width_o[n] <= wdata_i[CNT_W-1:0];
      if (hit_status)    err_q <= 1'b0;
      else if (!hit_any) err_q <= 1'b1;
    end
  end

  always_comb begin
    rdata_o = '0;
    if (hit_period) rdata_o = DATA_W'(period_o);
    if (hit_enable) rdata_o = DATA_W'(enable_o);
    if (hit_status) rdata_o = DATA_W'(err_q);
    for (int n = 0; n < NUM_CH; n++)
      if (hit_width[n]) rdata_o = DATA_W'(width_o[n]);
  end
endmodule

// File: rtl/servo_frame.sv
module servo_frame #(
  parameter int unsigned NUM_CH     = 8,
  parameter int unsigned CNT_W      = 32,
  parameter int unsigned RST_PERIOD = 1_000_000
) (
  input  logic                         clk_i,
  input  logic                         rst_ni,
  input  logic [CNT_W-1:0]             period_i,
  input  logic [NUM_CH-1:0][CNT_W-1:0] width_i,
  input  logic [NUM_CH-1:0]            enable_i,
  output logic [CNT_W-1:0]             cnt_o,
  output logic [CNT_W-1:0]             period_act_o,
  output logic [NUM_CH-1:0][CNT_W-1:0] width_act_o,
  output logic [NUM_CH-1:0]            enable_act_o
);
  logic wrap;

  // extra bit: period 0 or 1 wraps every tick without underflow
  assign wrap = (({1'b0, cnt_o} + (CNT_W+1)'(1)) >= {1'b0, period_act_o});

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_o        <= '0;
      period_act_o <= CNT_W'(RST_PERIOD);
      width_act_o  <= '0;
      enable_act_o <= '0;
    end else if (wrap) begin
      cnt_o        <= '0;
      period_act_o <= period_i;
      width_act_o  <= width_i;
      enable_act_o <= enable_i;
    end else begin
      cnt_o <= cnt_o + CNT_W'(1);
    end
  end
endmodule

// File: rtl/servo_chan.sv
module servo_chan #(
  parameter int unsigned CNT_W = 32
) (
  input  logic [CNT_W-1:0] cnt_i,
  input  logic [CNT_W-1:0] width_i,
  input  logic             en_i,
  output logic             pulse_o
);
  assign pulse_o = en_i && (cnt_i < width_i);
endmodule

// File: rtl/servo_pulse_gen.sv
module servo_pulse_gen import servo_pkg::*; #(
  parameter int unsigned NUM_CH     = 8,
  parameter int unsigned CNT_W      = 32,
  parameter int unsigned ADDR_W     = 8,
  parameter int unsigned DATA_W     = 32,
  parameter int unsigned RST_PERIOD = 1_000_000
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic [NUM_CH-1:0] servo_o
);
  logic [CNT_W-1:0]             period_sh, period_act, frame_cnt;
  logic [NUM_CH-1:0][CNT_W-1:0] width_sh, width_act;
  logic [NUM_CH-1:0]            enable_sh, enable_act;

  servo_regs #(
    .NUM_CH(NUM_CH), .CNT_W(CNT_W), .ADDR_W(ADDR_W),
    .DATA_W(DATA_W), .RST_PERIOD(RST_PERIOD)
  ) u_regs (
    .clk_i, .rst_ni, .wr_en_i, .addr_i, .wdata_i, .rdata_o,
    .period_o(period_sh), .width_o(width_sh), .enable_o(enable_sh)
  );

  servo_frame #(
    .NUM_CH(NUM_CH), .CNT_W(CNT_W), .RST_PERIOD(RST_PERIOD)
  ) u_frame (
    .clk_i, .rst_ni,
    .period_i(period_sh), .width_i(width_sh), .enable_i(enable_sh),
    .cnt_o(frame_cnt), .period_act_o(period_act),
    .width_act_o(width_act), .enable_act_o(enable_act)
  );

  for (genvar n = 0; n < NUM_CH; n++) begin : g_chan
    servo_chan #(.CNT_W(CNT_W)) u_chan (
      .cnt_i(frame_cnt), .width_i(width_act[n]),
      .en_i(enable_act[n]), .pulse_o(servo_o[n])
    );
  end
endmodule

// File: rtl/servo_pulse_gen_chk.sv
module servo_pulse_gen_chk import servo_pkg::*; #(
  parameter int unsigned NUM_CH = 8,
  parameter int unsigned CNT_W  = 32,
  parameter int unsigned ADDR_W = 8
) (
  input logic                         clk_i,
  input logic                         rst_ni,
  input logic                         wr_en_i,
  input logic [ADDR_W-1:0]            addr_i,
  input logic                         rd_bit0_i,
  input logic [NUM_CH-1:0]            servo_i,
  input logic [CNT_W-1:0]             cnt_i,
  input logic [CNT_W-1:0]             period_act_i,
  input logic [NUM_CH-1:0][CNT_W-1:0] width_act_i,
  input logic [NUM_CH-1:0]            en_act_i
);
  logic addr_ok;
  assign addr_ok = (addr_i <= ADDR_W'(ADDR_STATUS)) ||
                   ((addr_i >= ADDR_W'(ADDR_WIDTH0)) &&
                    (addr_i <  ADDR_W'(ADDR_WIDTH0 + NUM_CH)));

  a_r2_cnt_in_frame: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_i == '0) || (cnt_i < period_act_i));

  a_r6_period_at_boundary: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(period_act_i) |-> (cnt_i == '0));

  a_r6_enable_at_boundary: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(en_act_i) |-> (cnt_i == '0));

  a_r8_bad_write_flags: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && !addr_ok) |=> ((addr_i != ADDR_W'(ADDR_STATUS)) || rd_bit0_i));

  a_r8_status_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && (addr_i == ADDR_W'(ADDR_STATUS))) |=>
      ((addr_i != ADDR_W'(ADDR_STATUS)) || !rd_bit0_i));

  for (genvar n = 0; n < NUM_CH; n++) begin : g_ch
    a_r2_rise_at_start: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(servo_i[n]) |-> (cnt_i == '0));

    a_r3_fall_at_width: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $fell(servo_i[n]) |-> ((cnt_i == width_act_i[n]) || (cnt_i == '0)));

    a_r4_zero_width_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (width_act_i[n] == '0) |-> !servo_i[n]);

    a_r5_disabled_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !en_act_i[n] |-> !servo_i[n]);
  end
endmodule

bind servo_pulse_gen servo_pulse_gen_chk #(
  .NUM_CH(NUM_CH), .CNT_W(CNT_W), .ADDR_W(ADDR_W)
) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .wr_en_i(wr_en_i), .addr_i(addr_i),
  .rd_bit0_i(rdata_o[0]), .servo_i(servo_o), .cnt_i(frame_cnt),
  .period_act_i(period_act), .width_act_i(width_act), .en_act_i(enable_act)
);

// File: tb/sim_servo_pulse_gen.sv
module sim_servo_pulse_gen;
  localparam int CLK_PERIOD = 20;
  localparam int NCH        = 8;
  localparam int RST_P      = 64;

  logic            clk = 1'b0;
  logic            rst_ni;
  logic            wr_en;
  logic [7:0]      addr;
  logic [31:0]     wdata;
  logic [31:0]     rdata;
  logic [NCH-1:0]  servo;

  servo_pulse_gen #(.NUM_CH(NCH), .RST_PERIOD(RST_P)) u0 (
    .clk_i(clk), .rst_ni(rst_ni), .wr_en_i(wr_en), .addr_i(addr),
    .wdata_i(wdata), .rdata_o(rdata), .servo_o(servo)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int n_cmp = 0, n_bad = 0;
  bit done = 0;

  // scoreboard: ch -1 = frame length item, else falling-edge pulse width
  int q_ch[$];
  int q_val[$];
  bit mon_on = 0;
  int viol = 0;

  task automatic check(string req, string what, longint act, longint exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic push(int c, int v);
    q_ch.push_back(c);
    q_val.push_back(v);
  endtask

  task automatic sb_cmp(int c, int v);
    int ec, ev;
    n_cmp++;
    if (q_ch.size() == 0) begin
      n_bad++;
      $display("FAIL R3 unexpected item ch %0d: actual %0d expected none", c, v);
    end else begin
      ec = q_ch.pop_front();
      ev = q_val.pop_front();
      if (ec != c || ev != v) begin
        n_bad++;
        $display("FAIL %s item: actual ch %0d val %0d expected ch %0d val %0d",
                 (ec < 0) ? "R2" : "R3", c, v, ec, ev);
      end
    end
  endtask

  // monitor
  longint        cyc = 0, prev_rise = 0;
  bit            have_rise = 0;
  logic [NCH-1:0] prev_s = '0;
  int            hi [NCH];

  initial for (int c = 0; c < NCH; c++) hi[c] = 0;

  always @(negedge clk) begin
    cyc++;
    if (servo[0] && !prev_s[0]) begin
      if (have_rise && mon_on) sb_cmp(-1, int'(cyc - prev_rise));
      prev_rise = cyc;
      have_rise = 1;
    end
    for (int c = 0; c < NCH; c++) begin
      if (servo[c]) hi[c]++;
      else begin
        if (prev_s[c] && mon_on) sb_cmp(c, hi[c]);
        hi[c] = 0;
      end
    end
    // R4/R5 levels: ch3,ch4 full-frame high; ch2 zero width; ch7 disabled
    if (mon_on && (!servo[3] || !servo[4] || servo[2] || servo[7])) viol++;
    prev_s = servo;
  end

  task automatic wr(logic [7:0] a, logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(logic [7:0] a, output logic [31:0] d);
    wr_en = 1'b0; addr = a;
    #1;
    d = rdata;
  endtask

  task automatic push_frame(int w1);
    push(6, 1); push(0, 5);
    if (w1 < 20) begin push(1, w1); push(5, 20); end
    else begin push(5, 20); push(1, w1); end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    int n;
    rst_ni = 1'b0; wr_en = 1'b0; addr = '0; wdata = '0;
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);

    // R1 reset state
    check("R1", "outputs", servo, 0);
    rd(8'h00, v); check("R1", "period", v, RST_P);
    rd(8'h01, v); check("R1", "enable", v, 0);
    rd(8'h13, v); check("R1", "width3", v, 0);
    rd(8'h02, v); check("R1", "status", v, 0);

    // configure during the reset-default frame
    wr(8'h00, 40);
    wr(8'h10, 5);  wr(8'h11, 12); wr(8'h12, 0);  wr(8'h13, 50);
    wr(8'h14, 32'hFFFF_FFFF);     wr(8'h15, 20); wr(8'h16, 1);
    wr(8'h17, 10);
    wr(8'h01, 8'h7F);
    check("R6", "outputs before boundary", servo, 0);
    rd(8'h14, v); check("R7", "width4 readback", v, 32'hFFFF_FFFF);

    while (!servo[0]) @(negedge clk);
    check("R2", "common rise pattern", servo, 8'h7B);
    push_frame(12);  push(-1, 40);
    push_frame(30);  push(-1, 50);
    push_frame(30);
    mon_on = 1;
    // mid-frame update: visible one boundary later (R6)
    wr(8'h11, 30);
    wr(8'h00, 50);
    rd(8'h11, v); check("R7", "pending width readback", v, 30);
    while (q_ch.size() != 0) @(negedge clk);
    repeat (2) @(negedge clk);
    mon_on = 0;
    check("R4", "full/zero/disabled level violations", viol, 0);

    // R5 disable channel 0
    wr(8'h01, 8'h7E);
    repeat (60) @(negedge clk);
    begin
      int h0 = 0, h5 = 0;
      for (int i = 0; i < 50; i++) begin
        @(negedge clk);
        if (servo[0]) h0++;
        if (servo[5]) h5++;
      end
      check("R5", "disabled ch0 high ticks", h0, 0);
      check("R5", "enabled ch5 high ticks per frame", h5, 20);
    end

    // R7 read-modify-write of enable
    rd(8'h01, v); check("R7", "enable readback", v, 8'h7E);
    wr(8'h01, v | 32'h1);
    rd(8'h01, v); check("R7", "enable after rmw", v, 8'h7F);
    @(negedge clk);
    while (!servo[0]) @(negedge clk);
    n = 0;
    while (servo[0]) begin n++; @(negedge clk); end
    check("R3", "ch0 width after re-enable", n, 5);

    // R8 error flag
    rd(8'h02, v); check("R8", "status clean", v, 0);
    wr(8'h05, 123);
    rd(8'h02, v); check("R8", "status after bad write", v, 1);
    rd(8'h05, v); check("R8", "unused address reads 0", v, 0);
    rd(8'h00, v); check("R8", "period untouched", v, 50);
    rd(8'h10, v); check("R8", "width0 untouched", v, 5);
    wr(8'h02, 0);
    rd(8'h02, v); check("R8", "status cleared", v, 0);
    wr(8'h18, 7);
    rd(8'h02, v); check("R8", "status after write past last width", v, 1);
    rd(8'h17, v); check("R8", "width7 untouched", v, 10);
    wr(8'h02, 0);
    rd(8'h02, v); check("R8", "status cleared again", v, 0);

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule